// File: doc/BRIEF.md
# Link Time and Payload Measurement Counter

This block gathers one link statistic over a measurement window and keeps the total in a wide accumulator. Each cycle it adds one increment to the total. That increment is either a flag showing that the link sits in a chosen power or training state, or a count of payload units (16 bytes each) that moved in one direction for one traffic class. A single 32-bit control word sets three things: which quantity is measured, how long the window lasts, and whether a run is active.

A run starts when the start flag goes from 0 to 1. The same write clears the total. In manual mode the run lasts until software writes the start flag back to 0. In a timed mode the block counts reference ticks and stops by itself when the coded window has elapsed, and the start flag then reads back as 0. After a run ends, the total keeps its value until the next start. The total is presented as a low half and a high half. Both halves show the live value, so software that reads them at different times can see a carry move into the high half between its two reads.

There is no back-pressure anywhere in this block. The link state flags, the payload counts and the reference tick are plain per-cycle indications and are sampled on every clock. A control write takes effect in the cycle in which `cfg_we` is high.

Top module: `link_time_counter`

## Requirements
- R1: After reset, `cfg_rdata`, `res_lo` and `res_hi` are all 0.
- R2: Control word fields are: quantity select in bits 31:24, duration select in bits 15:8, start flag in bit 0. Every other bit reads back as 0. Writing with the start flag at 0 while idle does not start a run.
- R3: A write that moves the start flag from 0 to 1 clears the total. The total is 0 on the following cycle, and counting begins in the cycle after that write. A write with start flag 1 during a run does not clear the total, and the cycle of that write still counts.
- R4: Duration code 0x00 is manual. The block adds one increment per cycle while the start flag is 1. A write of start flag 0 stops the run, and the cycle of that write adds nothing.
- R5: Timed duration codes, in microseconds: 0x01 = 1000, 0x02 = 10000, 0x03 = 100000, 0x04 = 1000000, 0x05 = 2000000, 0x06 = 4000000, 0xFF = 4. The window length in ticks is that number divided by `US_PER_TICK`, with a minimum of 1. The run ends on the clock edge that carries the last tick of the window, and that cycle still counts. The start flag then reads 0.
- R6: While no run is active, the total holds its value.
- R7: Quantity code 0x00 adds 1 every cycle. Codes 0x01 to 0x09 add 1 in each cycle in which `link_state` bit (code − 1) is 1.
- R8: Quantity codes 0x20 to 0x23 add, every cycle, the payload count of lane (code − 0x20). Lane n occupies bits `n*UNIT_W` and up of `pay_units`.
- R9: Any other quantity code adds nothing.
- R10: The total is 2×`HALF_W` bits wide. `res_lo` is the low half and `res_hi` the high half. A carry out of the low half appears in the high half in the same cycle.
- R11: A duration code not listed in R5 behaves as manual. The run does not end on its own.
- R12: A write of start flag 0 during a timed window aborts the run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| link_state | input | 9 | Per-cycle link state flags; bit k is for quantity code k+1 |
| pay_units | input | 4*UNIT_W | Per-cycle payload counts in 16-byte units, four lanes |
| ref_tick | input | 1 | Reference time tick, one pulse per `US_PER_TICK` microseconds |
| res_lo | output | HALF_W | Low half of the total |
| res_hi | output | HALF_W | High half of the total |

## Verification
Between any input and any result there is exactly one register. A control write, or a cycle's inputs, show up in `res_lo`, `res_hi` and `cfg_rdata` just after the next rising edge: a cleared total one edge after the start write, and a timed stop one edge after the final tick. The bench drives every input on the falling edge and samples on the following falling edge. Each check therefore sees the state after a known number of edges. Window lengths, the two-half carry and the exclusion of the stop-write cycle are all counted from that edge.

// File: rtl/tla_pkg.sv
package tla_pkg;

  localparam int CTRL_W    = 32;
  localparam int SEL_W     = 8;
  localparam int REP_LSB   = 24;
  localparam int DUR_LSB   = 8;
  localparam int START_BIT = 0;
  localparam int N_STATE   = 9;
  localparam int N_LANE    = 4;
  localparam logic [SEL_W-1:0] PAY_BASE = 8'h20;
  localparam logic [SEL_W-1:0] REP_CYCLE = 8'h00;

  typedef struct packed {
    logic [SEL_W-1:0] rep;
    logic [SEL_W-1:0] dur;
    logic             start;
  } ctrl_t;

  // window length in microseconds; 0 means manual
  function automatic logic [31:0] window_us(input logic [SEL_W-1:0] code);
    case (code)
      8'h01:   window_us = 32'd1000;
      8'h02:   window_us = 32'd10000;
      8'h03:   window_us = 32'd100000;
      8'h04:   window_us = 32'd1000000;
      8'h05:   window_us = 32'd2000000;
      8'h06:   window_us = 32'd4000000;
      8'hFF:   window_us = 32'd4;
      default: window_us = 32'd0;
    endcase
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[REP_LSB +: SEL_W] = c.rep;
    w[DUR_LSB +: SEL_W] = c.dur;
    w[START_BIT]        = c.start;
    return w;
  endfunction

endpackage

// File: rtl/tla_window.sv
module tla_window
  import tla_pkg::*;
#(
  parameter int US_PER_TICK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wr_rep,
  input  logic [SEL_W-1:0] wr_dur,
  input  logic             wr_start,
  input  logic             ref_tick,
  output ctrl_t            cfg,
  output logic             run,
  output logic             clear
);

  localparam int TCNT_W = 32;

  ctrl_t             cfg_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [TCNT_W-1:0] win_raw;
  logic [TCNT_W-1:0] win_ticks;
  logic              timed;
  logic              start_wr;
  logic              stop_wr;
  logic              tick_run;
  logic              last_tick;

  assign win_raw   = window_us(cfg_q.dur) / TCNT_W'(US_PER_TICK);
  assign timed     = (window_us(cfg_q.dur) != '0);
  assign win_ticks = (win_raw == '0) ? TCNT_W'(1) : win_raw;

  assign start_wr  = we & wr_start;
  assign stop_wr   = we & ~wr_start;
  assign clear     = start_wr & ~cfg_q.start;
  assign run       = cfg_q.start & ~stop_wr;
  assign tick_run  = run & timed & ref_tick;
  assign last_tick = tick_run & (tcnt_q == win_ticks - TCNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      tcnt_q <= '0;
    end else begin
      if (we) begin
        cfg_q.rep <= wr_rep;
        cfg_q.dur <= wr_dur;
      end
      if (clear) begin
        cfg_q.start <= 1'b1;
        tcnt_q      <= '0;
      end else if (stop_wr || last_tick) begin
        cfg_q.start <= 1'b0;
      end else if (tick_run) begin
        tcnt_q <= tcnt_q + TCNT_W'(1);
      end
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/tla_select.sv
module tla_select
  import tla_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic [SEL_W-1:0]         rep,
  input  logic [N_STATE-1:0]       link_state,
  input  logic [N_LANE*UNIT_W-1:0] pay_units,
  output logic [UNIT_W-1:0]        incr
);

  logic [N_STATE-1:0] st_hit;
  logic [UNIT_W-1:0]  lane_term [N_LANE];

  for (genvar g = 0; g < N_STATE; g++) begin : g_state
    assign st_hit[g] = (rep == SEL_W'(g + 1)) & link_state[g];
  end

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    assign lane_term[l] = (rep == PAY_BASE + SEL_W'(l)) ?
                          pay_units[l*UNIT_W +: UNIT_W] : '0;
  end

  always_comb begin
    incr = '0;
    if ((rep == REP_CYCLE) || (|st_hit)) incr = UNIT_W'(1);
    for (int l = 0; l < N_LANE; l++) incr = incr | lane_term[l];
  end

endmodule

// File: rtl/tla_accum.sv
module tla_accum #(
  parameter int HALF_W = 32,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [INC_W-1:0]  incr,
  output logic [HALF_W-1:0] lo,
  output logic [HALF_W-1:0] hi
);

  localparam int SUM_W = HALF_W + 1;

  logic [HALF_W-1:0] lo_q, hi_q;
  logic [SUM_W-1:0]  lo_sum;

  assign lo_sum = {1'b0, lo_q} + {{(SUM_W-INC_W){1'b0}}, incr};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (run) begin
      lo_q <= lo_sum[HALF_W-1:0];
      hi_q <= hi_q + HALF_W'(lo_sum[HALF_W]);
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;

endmodule

// File: rtl/link_time_counter.sv
module link_time_counter
  import tla_pkg::*;
#(
  parameter int HALF_W      = 32,
  parameter int UNIT_W      = 8,
  parameter int US_PER_TICK = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic [8:0]               link_state,
  input  logic [4*UNIT_W-1:0]      pay_units,
  input  logic                     ref_tick,
  output logic [HALF_W-1:0]        res_lo,
  output logic [HALF_W-1:0]        res_hi
);

  ctrl_t             cfg;
  logic              run;
  logic              clear;
  logic [UNIT_W-1:0] incr;
  logic              unused_wbits;

  assign unused_wbits = ^{cfg_wdata[23:16], cfg_wdata[7:1]};

  tla_window #(.US_PER_TICK(US_PER_TICK)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wr_rep   (cfg_wdata[REP_LSB +: SEL_W]),
    .wr_dur   (cfg_wdata[DUR_LSB +: SEL_W]),
    .wr_start (cfg_wdata[START_BIT]),
    .ref_tick (ref_tick),
    .cfg      (cfg),
    .run      (run),
    .clear    (clear)
  );

  tla_select #(.UNIT_W(UNIT_W)) u_sel (
    .rep        (cfg.rep),
    .link_state (link_state),
    .pay_units  (pay_units),
    .incr       (incr)
  );

  tla_accum #(.HALF_W(HALF_W), .INC_W(UNIT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .run   (run),
    .incr  (incr),
    .lo    (res_lo),
    .hi    (res_hi)
  );

  assign cfg_rdata = pack_ctrl(cfg);

endmodule

// File: rtl/link_time_counter_chk.sv
module link_time_counter_chk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              wr_start,
  input logic [31:0]       cfg_rdata,
  input logic              ref_tick,
  input logic [HALF_W-1:0] res_lo,
  input logic [HALF_W-1:0] res_hi
);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[23:16] == 8'h00) && (cfg_rdata[7:1] == 7'h00));

  // R3
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && wr_start && !cfg_rdata[0]) |=> ((res_lo == '0) && (res_hi == '0)));

  // R3
  start_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[0]) |-> $past(cfg_we && wr_start));

  // R4
  stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_start) |=> !cfg_rdata[0]);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[0] && !cfg_we) |=> ($stable(res_lo) && $stable(res_hi)));

  // R5
  self_stop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cfg_rdata[0]) && !$past(cfg_we)) |-> $past(ref_tick));

  // R11
  manual_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[0] && !cfg_we && (cfg_rdata[15:8] == 8'h00)) |=> cfg_rdata[0]);

endmodule

bind link_time_counter link_time_counter_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .wr_start  (cfg_wdata[0]),
  .cfg_rdata (cfg_rdata),
  .ref_tick  (ref_tick),
  .res_lo    (res_lo),
  .res_hi    (res_hi)
);

// File: tb/sim_link_time_counter.sv
module sim_link_time_counter;

  localparam int CLK_PERIOD = 10;
  localparam int HW  = 12;
  localparam int UW  = 8;
  localparam int TPU = 1;
  localparam int TW  = 2 * HW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [31:0]       cfg_wdata;
  logic [31:0]       cfg_rdata;
  logic [8:0]        link_state;
  logic [4*UW-1:0]   pay_units;
  logic              ref_tick;
  logic [HW-1:0]     res_lo, res_hi;

  int errs   = 0;
  int checks = 0;
  int tick_div = 0;
  int phase    = 0;

  logic          m_start;
  logic [7:0]    m_rep, m_dur;
  logic [TW-1:0] m_acc;
  int            m_tcnt;

  link_time_counter #(.HALF_W(HW), .UNIT_W(UW), .US_PER_TICK(TPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .link_state(link_state), .pay_units(pay_units),
    .ref_tick(ref_tick), .res_lo(res_lo), .res_hi(res_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [7:0] rep, input logic [7:0] dur,
                                     input logic st);
    return {rep, 8'h00, dur, 7'h00, st};
  endfunction

  function automatic int win_len(input logic [7:0] d);
    int us, t;
    case (d)
      8'h01: us = 1000;    8'h02: us = 10000;   8'h03: us = 100000;
      8'h04: us = 1000000; 8'h05: us = 2000000; 8'h06: us = 4000000;
      8'hFF: us = 4;
      default: us = 0;
    endcase
    t = us / TPU;
    if (us != 0 && t == 0) t = 1;
    return t;
  endfunction

  function automatic int exp_inc(input logic [7:0] rep);
    if (rep == 8'h00) return 1;
    if (rep >= 8'h01 && rep <= 8'h09) return int'(link_state[rep - 8'h01]);
    if (rep >= 8'h20 && rep <= 8'h23) return int'(pay_units[(rep - 8'h20)*UW +: UW]);
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: model the requirements, step the edge, land on the falling edge
  task automatic cyc();
    logic ns;
    ref_tick = (tick_div != 0) && ((phase % tick_div) == (tick_div - 1));
    phase++;
    ns = m_start;
    if (cfg_we && cfg_wdata[0] && !m_start) begin
      ns = 1'b1; m_acc = '0; m_tcnt = 0;
    end else if (cfg_we && !cfg_wdata[0]) begin
      ns = 1'b0;
    end else if (m_start) begin
      m_acc = m_acc + TW'(exp_inc(m_rep));
      if (win_len(m_dur) != 0 && ref_tick) begin
        if (m_tcnt == win_len(m_dur) - 1) ns = 1'b0;
        else m_tcnt++;
      end
    end
    if (cfg_we) begin
      m_rep = cfg_wdata[31:24];
      m_dur = cfg_wdata[15:8];
    end
    @(posedge clk);
    m_start = ns;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " total"}, 64'({res_hi, res_lo}), 64'(m_acc));
    chk({tag, " start"}, 64'(cfg_rdata[0]), 64'(m_start));
  endtask

  task automatic t_reset();
    chk("R1 rdata", 64'(cfg_rdata), 64'd0);
    chk("R1 lo", 64'(res_lo), 64'd0);
    chk("R1 hi", 64'(res_hi), 64'd0);
  endtask

  task automatic t_fields();
    wr(32'hFFFF_FFFE);
    chk("R2 readback", 64'(cfg_rdata), 64'hFF00_FF00);
    idle(5);
    chk("R2 no start", 64'({res_hi, res_lo}), 64'd0);
    wr(32'h0);
  endtask

  task automatic t_manual();
    wr(mk(8'h00, 8'h00, 1'b1));
    idle(20);
    chk("R4 running", 64'(cfg_rdata[0]), 64'd1);
    wr(mk(8'h00, 8'h00, 1'b0));
    chk("R4 manual count", 64'({res_hi, res_lo}), 64'd20);
    chk("R4 stopped", 64'(cfg_rdata[0]), 64'd0);
    idle(10);
    chk("R6 hold", 64'({res_hi, res_lo}), 64'd20);
  endtask

  task automatic t_state();
    wr(mk(8'h05, 8'h00, 1'b1));
    for (int i = 0; i < 16; i++) begin
      link_state = (i % 3 == 0) ? 9'h010 : 9'h1EF;
      cyc();
    end
    link_state = '0;
    wr(mk(8'h05, 8'h00, 1'b0));
    chk("R7 state count", 64'({res_hi, res_lo}), 64'd6);
    chk_model("R7");
  endtask

  task automatic t_payload();
    wr(mk(8'h21, 8'h00, 1'b1));
    pay_units = {8'd77, 8'd77, 8'd200, 8'd77};
    idle(30);
    pay_units = '0;
    wr(mk(8'h21, 8'h00, 1'b0));
    chk("R8 payload total", 64'({res_hi, res_lo}), 64'd6000);
    chk("R10 hi carry", 64'(res_hi), 64'd1);
    chk("R10 lo", 64'(res_lo), 64'd1904);
  endtask

  task automatic t_badrep();
    wr(mk(8'h15, 8'h00, 1'b1));
    chk("R3 cleared", 64'({res_hi, res_lo}), 64'd0);
    link_state = '1; pay_units = '1;
    idle(10);
    chk("R9 no count", 64'({res_hi, res_lo}), 64'd0);
    link_state = '0; pay_units = '0;
    wr(mk(8'h15, 8'h00, 1'b0));
  endtask

  task automatic t_restart();
    wr(mk(8'h00, 8'h00, 1'b1));
    idle(5);
    wr(mk(8'h00, 8'h00, 1'b1));
    idle(2);
    chk("R3 no clear mid-run", 64'({res_hi, res_lo}), 64'd8);
    wr(mk(8'h00, 8'h00, 1'b0));
    wr(mk(8'h00, 8'h00, 1'b1));
    chk("R3 restart clears", 64'({res_hi, res_lo}), 64'd0);
    wr(mk(8'h00, 8'h00, 1'b0));
  endtask

  task automatic t_timed_short();
    tick_div = 3;
    wr(mk(8'h00, 8'hFF, 1'b1));
    idle(30);
    chk_model("R5 4us window");
    chk("R5 flag clear", 64'(cfg_rdata[0]), 64'd0);
    idle(5);
    chk_model("R6 after window");
    tick_div = 0;
  endtask

  task automatic t_timed_ms();
    tick_div = 1;
    wr(mk(8'h00, 8'h01, 1'b1));
    idle(999);
    chk("R5 still running", 64'(cfg_rdata[0]), 64'd1);
    idle(1);
    chk("R5 1ms total", 64'({res_hi, res_lo}), 64'd1000);
    chk("R5 1ms flag", 64'(cfg_rdata[0]), 64'd0);
    idle(10);
    chk("R6 1ms hold", 64'({res_hi, res_lo}), 64'd1000);
    tick_div = 0;
  endtask

  task automatic t_abort();
    tick_div = 1;
    wr(mk(8'h00, 8'h02, 1'b1));
    idle(50);
    wr(mk(8'h00, 8'h02, 1'b0));
    chk("R12 abort total", 64'({res_hi, res_lo}), 64'd50);
    chk("R12 abort flag", 64'(cfg_rdata[0]), 64'd0);
    tick_div = 0;
  endtask

  task automatic t_undef_dur();
    tick_div = 1;
    wr(mk(8'h00, 8'h09, 1'b1));
    idle(50);
    chk("R11 still running", 64'(cfg_rdata[0]), 64'd1);
    wr(mk(8'h00, 8'h09, 1'b0));
    chk("R11 total", 64'({res_hi, res_lo}), 64'd50);
    tick_div = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    link_state = '0; pay_units = '0; ref_tick = 1'b0;
    m_start = 1'b0; m_rep = '0; m_dur = '0; m_acc = '0; m_tcnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_manual();
    t_state();
    t_payload();
    t_badrep();
    t_restart();
    t_timed_short();
    t_timed_ms();
    t_abort();
    t_undef_dur();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule